// File: doc/BRIEF.md
# Replicated Multiported Register File

This block is a unified physical register file in which integer and floating-point values share one storage space. It offers many read ports without building one array that carries all of them. The whole storage array is kept in several identical copies, two by default. Every write is sent to all copies in the same clock edge. Each copy drives its own group of read ports, so a single array only ever carries a fraction of the read ports.

With the default sizing the file has 512 entries of 64 bits and 8 write ports. It has two copies, each serving 8 read ports, which gives 16 read ports in total. The 512 entries hold 256 architectural registers (four thread contexts, each with 32 integer and 32 floating-point registers) plus 256 rename registers. Mapping from logical to physical register numbers is done outside this block, and so are forwarding and thread bookkeeping.

Reads are purely combinational and writes take effect on the rising clock edge. The block has no state machine; it has one storage state per copy, and that state changes only on reset or on an enabled write.

Top module: `rrf_top`

## Requirements
- R1: While the active-low reset is asserted, every entry in every copy is cleared to zero, so the first reads after reset return zero on all read ports.
- R2: When bit p of the write enable is 1 on a rising edge, the entry addressed by write address field p (bits p*AW upward) takes write data field p (bits p*WIDTH upward) in every copy, and reads return it from the next cycle on.
- R3: Read port k takes its address from bits k*AW upward of the read address bus and returns that entry's value on bits k*WIDTH upward of the read data bus, in the same cycle. Ports 0 to RPC-1 are served by copy 0, ports RPC to 2*RPC-1 by copy 1, and so on.
- R4: All copies hold the same contents at all times, so any two read ports given the same address return the same value.
- R5: When several enabled write ports name the same address on one edge, the highest-numbered of them sets the stored value in every copy.
- R6: A read of an address that is being written in the same cycle returns the value held before that write; there is no internal forwarding.
- R7: A write port whose enable bit is 0 changes no entry, whatever its address and data carry.
- R8: An entry that no enabled write port addresses keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes land on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset that clears all copies |
| wr_en_i | input | NW | One enable bit per write port |
| wr_addr_i | input | NW*AW | Write addresses, port p in bits p*AW upward |
| wr_data_i | input | NW*WIDTH | Write data, port p in bits p*WIDTH upward |
| rd_addr_i | input | NCOPY*RPC*AW | Read addresses, port k in bits k*AW upward |
| rd_data_o | output | NCOPY*RPC*WIDTH | Read data, port k in bits k*WIDTH upward |

## Verification
The bench uses a small configuration: 16 entries, 3 write ports and two copies of 2 read ports each. It writes every address through a rotating write port and then reads every address through every read port, so a copy that missed a broadcast write would show up as a mismatch between ports of different groups. Collisions with two and then three ports on one address catch a design that lets the lowest port win, or that resolves the collision differently in each copy. A read of an address in the same cycle it is written catches any added forwarding. Writes with enables low but busy address and data buses catch a design that ignores the enable.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    // Default sizing of the file
    localparam int unsigned DEF_DEPTH = 512;
    localparam int unsigned DEF_WIDTH = 64;
    localparam int unsigned DEF_NW    = 8;
    localparam int unsigned DEF_RPC   = 8;
    localparam int unsigned DEF_NCOPY = 2;

    // Lane index helpers for flat port buses
    function automatic int unsigned lane_lo(input int unsigned lane, input int unsigned lane_w);
        return lane * lane_w;
    endfunction

endpackage

// File: rtl/rrf_bank.sv
module rrf_bank #(
    parameter int unsigned DEPTH = rrf_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = rrf_pkg::DEF_WIDTH,
    parameter int unsigned NW    = rrf_pkg::DEF_NW,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NW-1:0]         wr_en_i,
    input  logic [NW*AW-1:0]      wr_addr_i,
    input  logic [NW*WIDTH-1:0]   wr_data_i,
    output logic [WIDTH-1:0]      mem_o [DEPTH]
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Ports are applied in ascending order, so the last enabled port wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int e = 0; e < int'(DEPTH); e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            for (int p = 0; p < int'(NW); p++) begin
                if (wr_en_i[p]) begin
                    mem_q[wr_addr_i[rrf_pkg::lane_lo(p, AW) +: AW]]
                        <= wr_data_i[rrf_pkg::lane_lo(p, WIDTH) +: WIDTH];
                end
            end
        end
    end

    assign mem_o = mem_q;

    // Highest write port always lands its data
    logic [AW-1:0]    top_addr;
    logic [WIDTH-1:0] top_data;
    assign top_addr = wr_addr_i[(NW-1)*AW +: AW];
    assign top_data = wr_data_i[(NW-1)*WIDTH +: WIDTH];

    assert_top_port_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i[NW-1] |=> (mem_q[$past(top_addr)] == $past(top_data)))
        else $error("highest write port lost its write");

    // A lone port-0 write lands (R2)
    assert_single_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i == NW'(1)) |=>
            (mem_q[$past(wr_addr_i[AW-1:0])] == $past(wr_data_i[WIDTH-1:0])))
        else $error("single write did not land");

endmodule

// File: rtl/rrf_rd_port.sv
module rrf_rd_port #(
    parameter int unsigned DEPTH = rrf_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = rrf_pkg::DEF_WIDTH,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [WIDTH-1:0] mem_i [DEPTH],
    input  logic [AW-1:0]    addr_i,
    output logic [WIDTH-1:0] data_o
);

    always_comb begin
        data_o = mem_i[addr_i];
    end

endmodule

// File: rtl/rrf_top.sv
module rrf_top #(
    parameter int unsigned DEPTH = rrf_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = rrf_pkg::DEF_WIDTH,
    parameter int unsigned NW    = rrf_pkg::DEF_NW,
    parameter int unsigned RPC   = rrf_pkg::DEF_RPC,
    parameter int unsigned NCOPY = rrf_pkg::DEF_NCOPY,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned NR   = NCOPY * RPC
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NW-1:0]         wr_en_i,
    input  logic [NW*AW-1:0]      wr_addr_i,
    input  logic [NW*WIDTH-1:0]   wr_data_i,
    input  logic [NR*AW-1:0]      rd_addr_i,
    output logic [NR*WIDTH-1:0]   rd_data_o
);

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic [WIDTH-1:0] mem [DEPTH];

        // Every copy sees the identical write bundle
        rrf_bank #(
            .DEPTH (DEPTH),
            .WIDTH (WIDTH),
            .NW    (NW)
        ) bank_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i),
            .wr_addr_i (wr_addr_i),
            .wr_data_i (wr_data_i),
            .mem_o     (mem)
        );

        for (genvar r = 0; r < RPC; r++) begin : g_rd
            localparam int unsigned K = c * RPC + r;
            rrf_rd_port #(
                .DEPTH (DEPTH),
                .WIDTH (WIDTH)
            ) rd_i (
                .mem_i  (mem),
                .addr_i (rd_addr_i[K*AW +: AW]),
                .data_o (rd_data_o[K*WIDTH +: WIDTH])
            );

            // Same address on a port of copy 0 and of this copy gives the same data
            if (c > 0) begin : g_match
                localparam int unsigned K0 = r;
                assert_copies_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (rd_addr_i[K*AW +: AW] == rd_addr_i[K0*AW +: AW]) |->
                    (rd_data_o[K*WIDTH +: WIDTH] == rd_data_o[K0*WIDTH +: WIDTH]))
                    else $error("copies disagree");
            end

            // No writes and a steady address: the data holds (R7, R8)
            assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i == '0) |=>
                (($past(rd_addr_i[K*AW +: AW]) != rd_addr_i[K*AW +: AW]) ||
                 $stable(rd_data_o[K*WIDTH +: WIDTH])))
                else $error("entry changed without a write");

            // First cycle out of reset reads zero
            assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(rst_ni) |-> (rd_data_o[K*WIDTH +: WIDTH] == '0))
                else $error("entry not cleared by reset");
        end
    end

endmodule

// File: tb/rrf_top_tb.sv
module rrf_top_tb_top;

    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int NW    = 3;
    localparam int RPC   = 2;
    localparam int NCOPY = 2;
    localparam int AW    = 4;
    localparam int NR    = NCOPY * RPC;

    logic                 clk;
    logic                 rst_n;
    logic [NW-1:0]        wr_en;
    logic [NW*AW-1:0]     wr_addr;
    logic [NW*WIDTH-1:0]  wr_data;
    logic [NR*AW-1:0]     rd_addr;
    logic [NR*WIDTH-1:0]  rd_data;

    logic [WIDTH-1:0] model [DEPTH];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    rrf_top #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .NW    (NW),
        .RPC   (RPC),
        .NCOPY (NCOPY)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    initial clk = 0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic set_wr(input int p, input int a, input logic [WIDTH-1:0] d);
        wr_en[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*WIDTH +: WIDTH] = d;
    endtask

    // Update the model the way the requirements order collisions (R5)
    task automatic commit_model();
        for (int p = 0; p < NW; p++) begin
            if (wr_en[p]) model[wr_addr[p*AW +: AW]] = wr_data[p*WIDTH +: WIDTH];
        end
    endtask

    // Read every address through every port and compare (R3, R4, R8)
    task automatic scan_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < NR; k++) rd_addr[k*AW +: AW] = AW'((a + k) % DEPTH);
            #0.5;
            for (int k = 0; k < NR; k++) check(req, rd_data[k*WIDTH +: WIDTH], model[(a + k) % DEPTH]);
        end
    endtask

    // One write cycle: drive at negedge, commit at posedge, inputs released at next negedge
    task automatic edge_and_release();
        @(posedge clk);
        commit_model();
        @(negedge clk);
        wr_en = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        wr_en = '0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: everything zero after reset
        scan_all("R1");

        // R2, R6: every address written through a rotating port
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            set_wr(a % NW, a, WIDTH'(a * 37 + (a % NW) * 11 + 5));
            for (int k = 0; k < NR; k++) rd_addr[k*AW +: AW] = AW'(a);
            #0.5;
            for (int k = 0; k < NR; k++) check("R6", rd_data[k*WIDTH +: WIDTH], model[a]);
            edge_and_release();
            #0.5;
            for (int k = 0; k < NR; k++) check("R2", rd_data[k*WIDTH +: WIDTH], model[a]);
        end
        scan_all("R3");

        // R5: three-way collision, then two-way on lower ports
        @(negedge clk);
        set_wr(0, 5, 8'hA1);
        set_wr(1, 5, 8'hB2);
        set_wr(2, 5, 8'hC3);
        edge_and_release();
        for (int k = 0; k < NR; k++) rd_addr[k*AW +: AW] = AW'(5);
        #0.5;
        for (int k = 0; k < NR; k++) check("R5", rd_data[k*WIDTH +: WIDTH], 8'hC3);

        @(negedge clk);
        set_wr(0, 9, 8'h44);
        set_wr(1, 9, 8'h55);
        set_wr(2, 2, 8'h66);
        edge_and_release();
        for (int k = 0; k < NR; k++) rd_addr[k*AW +: AW] = AW'(9);
        #0.5;
        for (int k = 0; k < NR; k++) check("R5", rd_data[k*WIDTH +: WIDTH], 8'h55);

        // R7: enables low with busy buses
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            for (int p = 0; p < NW; p++) begin
                wr_addr[p*AW +: AW] = AW'(a);
                wr_data[p*WIDTH +: WIDTH] = ~model[a];
            end
            wr_en = '0;
            @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < NR; k++) rd_addr[k*AW +: AW] = AW'(a);
            #0.5;
            for (int k = 0; k < NR; k++) check("R7", rd_data[k*WIDTH +: WIDTH], model[a]);
        end

        // R8: sparse writes, all other entries keep their value
        @(negedge clk);
        set_wr(1, 0, 8'h0F);
        set_wr(2, 15, 8'hF0);
        edge_and_release();
        scan_all("R8");
        scan_all("R4");

        finish_run();
    end

endmodule